// File: doc/BRIEF.md
# Byte-Stream to Dword Program Packer

This block sits between a byte-oriented write source and a flash command sequencer that can only program whole aligned 32-bit words. A request gives a byte start address and a byte count. The bytes then arrive one at a time on a valid/ready stream. The packer assembles them into aligned dwords and hands each finished dword to the sequencer over a request/acknowledge port. The sequencer answers each dword with a pass or fail result.

The target memory can only clear bits when it programs. For that reason, every byte lane of a dword that the request does not cover is filled with 0xFF, so the neighbouring bytes already stored in flash keep their contents. Bytes are placed little-endian: the byte at the lowest address lands in bits 7:0.

The packer stops at the first failed program and reports an error. It also reports the number of bytes that were committed by the dwords that succeeded.

Top module: `wpk_top`

## Requirements
- R1: When the start address is not a multiple of 4, the first program operation targets the start address with its two low bits cleared, and every lane below the start offset carries 0xFF.
- R2: The first dword takes input bytes until its lane 3 is filled or the count is used up. Any lane left above the last byte carries 0xFF.
- R3: Every dword between the first and the last is fully populated from the stream. Successive program operations target addresses that are 4 apart, and every program address has bits 1:0 equal to zero.
- R4: A trailing remainder of 1 to 3 bytes goes into the low lanes of one final dword, starting at lane 0, with 0xFF in each upper lane.
- R5: Lane k (bits 8k+7:8k) of a program word holds the byte whose address is the dword address plus k.
- R6: A request with a count of zero raises `done` on the cycle after `start` is accepted, with `done_err` low, `done_count` zero and no program operation issued.
- R7: When the sequencer acknowledges a program with `prog_ok` low, the packer issues no further program operations. On the next cycle it raises `done` with `done_err` high, and `done_count` equals the number of bytes carried by the dwords that were acknowledged with `prog_ok` high.
- R8: A transfer in which every program passes ends with `done` high, `done_err` low and `done_count` equal to the requested count.
- R9: `in_ready` is low whenever `prog_req` is high. Once `prog_req` is raised, it stays high with `prog_addr` and `prog_data` unchanged until the cycle in which `prog_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a transfer; accepted only while `busy` is low |
| start_addr | input | ADDR_W | Byte address of the first byte |
| start_len | input | LEN_W | Number of bytes in the transfer |
| busy | output | 1 | High from acceptance of a transfer until the cycle after `done` |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_ready | output | 1 | Byte stream ready; a byte transfers when valid and ready are both high at a clock edge |
| prog_req | output | 1 | A dword program operation is pending |
| prog_addr | output | ADDR_W | Dword-aligned byte address of the program |
| prog_data | output | 32 | Word to program, with uncovered lanes at 0xFF |
| prog_ack | input | 1 | Sequencer has finished the pending program |
| prog_ok | input | 1 | Result that comes with `prog_ack`: high for pass, low for fail |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| done_err | output | 1 | With `done`: the transfer was aborted by a failed program |
| done_count | output | LEN_W | With `done`: number of bytes committed successfully |

## Verification
The bench aims at the ragged edges of a transfer:
- Start offsets of 1, 2 and 3 with counts that end inside the first dword, exactly at its end, or beyond it.
- Tail-only transfers and single-byte transfers.
- A zero-length request.

A packer that forgets to round the address down would program the wrong dword. Wrong padding would show up as lanes that are not 0xFF, which in flash would clear bits in neighbouring bytes. A wrong lane order would scramble bytes within each word.

Failures are injected on the first program and on a middle program. A design that keeps going after a failure would show extra program operations. A design that counts bytes before they are acknowledged would report a count that is too large. The scoreboard flags both.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

    localparam int BYTE_W    = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W    = BYTE_W * WORD_BYTES;
    localparam int LANE_W    = $clog2(WORD_BYTES);
    localparam int FILL_W    = LANE_W + 1;

    localparam logic [BYTE_W-1:0]  ERASED_BYTE = 8'hFF;
    localparam logic [LANE_W-1:0]  LANE_LAST   = LANE_W'(WORD_BYTES - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_PROG,
        ST_DONE
    } wpk_state_t;

    typedef struct packed {
        logic              clear;
        logic              wr;
        logic [LANE_W-1:0] lane;
        logic [BYTE_W-1:0] data;
    } lane_cmd_t;

    function automatic logic [WORD_W-1:0] erased_word();
        return {WORD_BYTES{ERASED_BYTE}};
    endfunction

endpackage

// File: rtl/wpk_lane_buf.sv
module wpk_lane_buf
    import wpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lane_cmd_t         cmd,
    output logic [WORD_W-1:0] word
);

    localparam logic [WORD_W-1:0] ERASED = erased_word();

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (rst || cmd.clear) begin
                lane_q <= ERASED[g*BYTE_W +: BYTE_W];
            end else if (cmd.wr && cmd.lane == LANE_W'(g)) begin
                lane_q <= cmd.data;
            end
        end

        assign word[g*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/wpk_ctrl.sv
module wpk_ctrl
    import wpk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              in_valid,
    input  logic              prog_ack,
    input  logic              prog_ok,
    output logic              buf_clear,
    output logic              buf_wr,
    output logic [LANE_W-1:0] wr_lane,
    output logic              in_ready,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic              busy,
    output logic              done,
    output logic              done_err,
    output logic [LEN_W-1:0]  done_count
);

    localparam int WADDR_W = ADDR_W - LANE_W;

    wpk_state_t         state;
    logic [WADDR_W-1:0] word_addr;
    logic [LANE_W-1:0]  lane;
    logic [LEN_W-1:0]   remaining;
    logic [FILL_W-1:0]  pending;
    logic [LEN_W-1:0]   written;
    logic               err;

    logic accept;
    logic word_closes;
    logic prog_pass;
    logic prog_fail;

    always_comb begin
        accept      = (state == ST_FILL) && in_valid;
        word_closes = (lane == LANE_LAST) || (remaining == LEN_W'(1));
        prog_pass   = (state == ST_PROG) && prog_ack && prog_ok;
        prog_fail   = (state == ST_PROG) && prog_ack && !prog_ok;
        buf_clear   = ((state == ST_IDLE) && start && (start_len != '0))
                    || (prog_pass && (remaining != '0));
        buf_wr      = accept;
        wr_lane     = lane;
    end

    assign in_ready   = (state == ST_FILL);
    assign prog_req   = (state == ST_PROG);
    assign prog_addr  = {word_addr, {LANE_W{1'b0}}};
    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_DONE);
    assign done_err   = err;
    assign done_count = written;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            word_addr <= '0;
            lane      <= '0;
            remaining <= '0;
            pending   <= '0;
            written   <= '0;
            err       <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        written <= '0;
                        err     <= 1'b0;
                        if (start_len == '0) begin
                            state <= ST_DONE;
                        end else begin
                            word_addr <= start_addr[ADDR_W-1:LANE_W];
                            lane      <= start_addr[LANE_W-1:0];
                            remaining <= start_len;
                            pending   <= '0;
                            state     <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (accept) begin
                        remaining <= remaining - LEN_W'(1);
                        lane      <= lane + LANE_W'(1);
                        pending   <= pending + FILL_W'(1);
                        if (word_closes) begin
                            state <= ST_PROG;
                        end
                    end
                end
                ST_PROG: begin
                    if (prog_pass) begin
                        written <= written + LEN_W'(pending);
                        if (remaining == '0) begin
                            state <= ST_DONE;
                        end else begin
                            word_addr <= word_addr + WADDR_W'(1);
                            lane      <= '0;
                            pending   <= '0;
                            state     <= ST_FILL;
                        end
                    end else if (prog_fail) begin
                        err   <= 1'b1;
                        state <= ST_DONE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/wpk_top.sv
module wpk_top
    import wpk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    output logic              busy,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [31:0]       prog_data,
    input  logic              prog_ack,
    input  logic              prog_ok,
    output logic              done,
    output logic              done_err,
    output logic [LEN_W-1:0]  done_count
);

    logic              buf_clear;
    logic              buf_wr;
    logic [LANE_W-1:0] wr_lane;
    lane_cmd_t         cmd;
    logic [WORD_W-1:0] word;

    wpk_ctrl #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .start_len  (start_len),
        .in_valid   (in_valid),
        .prog_ack   (prog_ack),
        .prog_ok    (prog_ok),
        .buf_clear  (buf_clear),
        .buf_wr     (buf_wr),
        .wr_lane    (wr_lane),
        .in_ready   (in_ready),
        .prog_req   (prog_req),
        .prog_addr  (prog_addr),
        .busy       (busy),
        .done       (done),
        .done_err   (done_err),
        .done_count (done_count)
    );

    always_comb begin
        cmd.clear = buf_clear;
        cmd.wr    = buf_wr;
        cmd.lane  = wr_lane;
        cmd.data  = in_data;
    end

    wpk_lane_buf buf_i (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .word (word)
    );

    assign prog_data = word;

endmodule

// File: rtl/wpk_checker.sv
module wpk_checker #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [LEN_W-1:0]  start_len,
    input logic              busy,
    input logic              in_ready,
    input logic              prog_req,
    input logic [ADDR_W-1:0] prog_addr,
    input logic [31:0]       prog_data,
    input logic              prog_ack,
    input logic              prog_ok,
    input logic              done,
    input logic              done_err,
    input logic [LEN_W-1:0]  done_count
);

    assert_ready_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        prog_req |-> !in_ready);

    assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
        (prog_req && !prog_ack) |=> (prog_req && $stable(prog_addr) && $stable(prog_data)));

    assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        prog_req |-> (prog_addr[1:0] == 2'b00));

    assert_empty_xfer_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && start_len == '0) |=> (done && !done_err && done_count == '0));

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (done && done_err) |-> $past(prog_ack && !prog_ok));

    assert_stop_after_fail_R7: assert property (@(posedge clk) disable iff (rst)
        (prog_req && prog_ack && !prog_ok) |=> (done && !prog_req));

endmodule

bind wpk_top wpk_checker #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_len  (start_len),
    .busy       (busy),
    .in_ready   (in_ready),
    .prog_req   (prog_req),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .prog_ack   (prog_ack),
    .prog_ok    (prog_ok),
    .done       (done),
    .done_err   (done_err),
    .done_count (done_count)
);

// File: tb/wpk_top_tb_top.sv
`timescale 1ns/1ps
module wpk_top_tb_top;

    localparam int ADDR_W = 24;
    localparam int LEN_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LEN_W-1:0]  start_len = '0;
    logic              busy;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_ready;
    logic              prog_req;
    logic [ADDR_W-1:0] prog_addr;
    logic [31:0]       prog_data;
    logic              prog_ack = 1'b0;
    logic              prog_ok = 1'b0;
    logic              done;
    logic              done_err;
    logic [LEN_W-1:0]  done_count;

    wpk_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_len(start_len), .busy(busy), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .prog_req(prog_req),
        .prog_addr(prog_addr), .prog_data(prog_data), .prog_ack(prog_ack),
        .prog_ok(prog_ok), .done(done), .done_err(done_err),
        .done_count(done_count)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [ADDR_W-1:0] exp_addr_q[$];
    logic [31:0]       exp_data_q[$];
    string             exp_tag_q[$];

    int    op_idx   = 0;
    int    fail_idx = -1;
    logic  got_done = 1'b0;
    logic  got_err  = 1'b0;
    int    got_cnt  = 0;
    string cur_tag  = "";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    // Flash sequencer model and scoreboard monitor.
    initial begin : responder
        forever begin
            @(negedge clk);
            if (prog_req) begin
                check(!in_ready, "R9", "in_ready during program", in_ready, 0);
                if (exp_addr_q.size() == 0) begin
                    check(0, cur_tag, "unexpected program op", prog_addr, 0);
                end else begin
                    logic [ADDR_W-1:0] ea;
                    logic [31:0]       ed;
                    string             et;
                    ea = exp_addr_q.pop_front();
                    ed = exp_data_q.pop_front();
                    et = exp_tag_q.pop_front();
                    check(prog_addr == ea, et, "program address", prog_addr, ea);
                    check(prog_data == ed, et, "program data", prog_data, ed);
                end
                repeat (op_idx % 3) @(negedge clk);
                prog_ack = 1'b1;
                prog_ok  = (op_idx != fail_idx);
                @(negedge clk);
                prog_ack = 1'b0;
                prog_ok  = 1'b0;
                op_idx++;
            end
        end
    end

    initial begin : done_mon
        forever begin
            @(negedge clk);
            if (done) begin
                got_done = 1'b1;
                got_err  = done_err;
                got_cnt  = int'(done_count);
            end
        end
    end

    // Driver: builds expected program operations, then streams the bytes.
    task automatic run_xfer(input int addr, input int len, input int fail_at,
                            input int gap, input int seed, input string tag);
        logic [7:0] bytes_a[64];
        int a, lane, rem, p, nops, exp_cnt, wait_cyc;
        bit exp_err;
        cur_tag = tag;
        for (int i = 0; i < 64; i++) bytes_a[i] = 8'((seed * 7 + i * 13 + 5) & 255);
        a = addr & ~3;
        lane = addr & 3;
        rem = len;
        p = 0;
        nops = 0;
        exp_cnt = 0;
        exp_err = 1'b0;
        while (rem > 0) begin
            logic [31:0] w;
            int n;
            w = 32'hFFFF_FFFF;
            n = 0;
            while (lane < 4 && rem > 0) begin
                w[lane*8 +: 8] = bytes_a[p];
                p++; lane++; rem--; n++;
            end
            exp_addr_q.push_back(ADDR_W'(a));
            exp_data_q.push_back(w);
            if (nops == 0) exp_tag_q.push_back({tag, " R1 R2 R5 head"});
            else if (n < 4) exp_tag_q.push_back({tag, " R4 R5 tail"});
            else exp_tag_q.push_back({tag, " R3 R5 middle"});
            if (fail_at >= 0 && nops == fail_at) exp_err = 1'b1;
            if (!(fail_at >= 0 && nops >= fail_at)) exp_cnt += n;
            nops++;
            a += 4;
            lane = 0;
        end
        op_idx   = 0;
        fail_idx = fail_at;
        got_done = 1'b0;
        @(negedge clk);
        start = 1'b1;
        start_addr = ADDR_W'(addr);
        start_len  = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (got_done) break;
            in_valid = 1'b1;
            in_data  = bytes_a[i];
            while (!in_ready && !got_done) @(negedge clk);
            if (got_done) break;
            @(negedge clk);
            in_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        in_valid = 1'b0;
        wait_cyc = 0;
        while (!got_done) begin
            @(negedge clk);
            wait_cyc++;
        end
        if (len == 0) check(wait_cyc <= 1, "R6", {tag, " done latency"}, wait_cyc, 1);
        if (exp_err) begin
            check(got_err == 1'b1, "R7", {tag, " done_err"}, got_err, 1);
            check(got_cnt == exp_cnt, "R7", {tag, " committed count"}, got_cnt, exp_cnt);
            check(op_idx == fail_at + 1, "R7", {tag, " ops issued"}, op_idx, fail_at + 1);
        end else begin
            check(got_err == 1'b0, (len == 0) ? "R6" : "R8", {tag, " done_err"}, got_err, 0);
            check(got_cnt == exp_cnt, (len == 0) ? "R6" : "R8", {tag, " done_count"}, got_cnt, exp_cnt);
            check(op_idx == nops, (len == 0) ? "R6" : "R8", {tag, " ops issued"}, op_idx, nops);
        end
        exp_addr_q.delete();
        exp_data_q.delete();
        exp_tag_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!in_ready && !prog_req && !busy && !done, "R9", "reset state idle",
              {in_ready, prog_req, busy, done}, 0);

        run_xfer(32'h100, 8, -1, 0, 1, "aligned8");
        run_xfer(32'h201, 2, -1, 1, 2, "off1len2");
        run_xfer(32'h303, 10, -1, 0, 3, "off3len10");
        run_xfer(32'h402, 2, -1, 2, 4, "off2len2");
        run_xfer(32'h500, 3, -1, 0, 5, "tail3");
        run_xfer(32'h600, 0, -1, 0, 6, "zero R6");
        run_xfer(32'h704, 1, -1, 0, 7, "single");
        run_xfer(32'h801, 12, 1, 0, 8, "failmid");
        run_xfer(32'h903, 6, 0, 1, 9, "failfirst");
        run_xfer(32'hA02, 40, -1, 1, 10, "long");
        run_xfer(32'hB01, 7, -1, 0, 11, "off1len7");

        finish_run();
    end

endmodule